// File: doc/BRIEF.md
# Most-Significant-Digit-First Online Redundant Binary Adder

This block adds two numbers written in redundant binary, where every digit is -1, 0 or +1. The digits arrive one per clock cycle, most significant first, one digit of each operand in the same cycle. The result leaves the block in the same way, one digit per accepted input pair. Because no carry can travel more than two digit positions, each result digit is final two digit cycles after the input pair of the same weight. That makes the block fit for chaining with other most-significant-first arithmetic, which can start on the high digits before the low digits are known.

Each digit position computes its pair sum and a one-bit flag that says whether either input digit is negative. When the next lower pair arrives, the position splits its pair sum into an interim carry and an interim sum, using the lower flag to choose between the two possible splits. The position one above it then adds that carry to its own interim sum, which was held in a register, to give its final digit. The first output digit has a weight one above the operand's most significant digit. Two zero digit pairs after the last real pair push the last two result digits out.

Top module: `rbo_online_adder`

## Requirements
- R1: Digits use a 2-bit two's-complement code: 2'b00 is 0, 2'b01 is +1 and 2'b11 is -1. An input code 2'b10 is read as 0. The output never carries 2'b10.
- R2: A stream starts with the pair accepted while `in_start` and `in_valid` are both high. Its pairs follow most significant first, and the last real pair is followed by two zero pairs.
- R3: `out_valid` stays low after the edge that accepts the first pair. It is high after each later edge that accepts a pair, so a stream of N digits plus two flush pairs gives exactly N+1 output digits.
- R4: If the output digits of a stream are weighted 2^N, 2^(N-1), ... 2^0 in the order they appear, their sum equals the integer sum of the two operands. This also sets the online delay to two accepted pairs.
- R5: A cycle with `in_valid` low changes no internal state. `out_valid` is low after that cycle and `out_digit` holds its value, and the sum of the stream is the same as without the idle cycle.
- R6: A new start may follow the last flush pair of the previous stream straight away. The new result does not depend on the earlier stream.
- R7: While `rst_n` is low at a rising edge, the reset is synchronous and clears all held sums, the start history, `out_valid` and `out_digit` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A digit pair is present this cycle |
| in_start | input | 1 | This pair is the most significant pair of a new stream |
| x_digit | input | 2 | Digit of operand X, code as in R1 |
| y_digit | input | 2 | Digit of operand Y, code as in R1 |
| out_valid | output | 1 | `out_digit` holds a new result digit |
| out_digit | output | 2 | Result digit, code as in R1 |

## Verification
The hardest case to reach from the ports is a carry that depends on two lower positions. This happens when a pair sum of plus or minus one meets a lower flag that forces the split with the opposite sign, and the next lower position then returns a carry that cancels the interim sum. An exhaustive sweep over every pair of three-digit operands creates each such neighbourhood, including the ones at the top digit and at the flush digits. Longer random streams with idle cycles, back-to-back starts and the unused input code then check that stalls and restarts leave the weighted sum unchanged.

// File: rtl/rbo_pkg.sv
// Package rbo_pkg
// Shared widths, types and digit-code helpers for the online redundant
// binary adder. Assumes the 2-bit two's-complement digit code of the brief.
package rbo_pkg;
    localparam int CODE_W = 2;             // width of one digit code
    localparam int PSUM_W = CODE_W + 1;    // pair sum spans -2..+2
    localparam int WIDE_W = CODE_W + 1;    // interim sum plus carry

    typedef logic [CODE_W-1:0]        rb_code_t;
    typedef logic signed [PSUM_W-1:0] psum_t;
    typedef logic signed [CODE_W-1:0] dig_t;

    // Map a digit code to its value; the unused code reads as zero.
    function automatic dig_t code_to_val(input rb_code_t c);
        case (c)
            2'b01:   return 2'sd1;
            2'b11:   return -2'sd1;
            default: return 2'sd0;
        endcase
    endfunction

    // Map a value in -1..+1 to its digit code.
    function automatic rb_code_t val_to_code(input dig_t v);
        case (v)
            2'sd1:   return 2'b01;
            -2'sd1:  return 2'b11;
            default: return 2'b00;
        endcase
    endfunction
endpackage

// File: rtl/rbo_pair_stage.sv
// Module rbo_pair_stage
// Forms the pair sum of one incoming digit pair and the flag that says
// whether either digit is negative. Pure combinational logic; assumes
// codes as in rbo_pkg.
module rbo_pair_stage
    import rbo_pkg::*;
(
    input  rb_code_t x_code,
    input  rb_code_t y_code,
    output psum_t    pair_sum,
    output logic     neg_flag
);
    dig_t x_val;
    dig_t y_val;

    // Decode both digits and add them with sign extension.
    always_comb begin
        x_val    = code_to_val(x_code);
        y_val    = code_to_val(y_code);
        pair_sum = psum_t'(x_val) + psum_t'(y_val);
        neg_flag = x_val[CODE_W-1] | y_val[CODE_W-1];
    end
endmodule

// File: rtl/rbo_split_stage.sv
// Module rbo_split_stage
// Splits a pair sum into an interim carry (one position up) and an interim
// sum. The flag of the next lower position picks the split, so that the
// carry arriving from below can never push the final digit out of -1..+1.
// Assumes pair_sum lies in -2..+2.
module rbo_split_stage
    import rbo_pkg::*;
(
    input  psum_t pair_sum,
    input  logic  lower_neg,
    output dig_t  carry_up,
    output dig_t  interim
);
    // Choose the carry and interim sum for each pair-sum value.
    always_comb begin
        carry_up = 2'sd0;
        interim  = 2'sd0;
        case (pair_sum)
            3'sd2:  carry_up = 2'sd1;
            -3'sd2: carry_up = -2'sd1;
            3'sd1: begin
                if (lower_neg) begin
                    interim  = 2'sd1;
                end else begin
                    carry_up = 2'sd1;
                    interim  = -2'sd1;
                end
            end
            -3'sd1: begin
                if (lower_neg) begin
                    carry_up = -2'sd1;
                    interim  = 2'sd1;
                end else begin
                    interim  = -2'sd1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rbo_online_adder.sv
// Module rbo_online_adder
// Digit-serial adder of two redundant binary operands, most significant
// digit first, with an online delay of two accepted pairs. It holds the
// previous pair sum (waiting for the lower flag) and the previous interim
// sum (waiting for the lower carry). Assumes every stream begins with
// in_start and ends with two zero pairs.
module rbo_online_adder
    import rbo_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic           in_start,
    input  logic [CODE_W-1:0] x_digit,
    input  logic [CODE_W-1:0] y_digit,
    output logic           out_valid,
    output logic [CODE_W-1:0] out_digit
);
    psum_t pair_now;
    logic  neg_now;
    psum_t psum_q;
    psum_t psum_prev;
    dig_t  isum_q;
    dig_t  carry_up;
    dig_t  interim_up;
    logic  started_q;
    logic signed [WIDE_W-1:0] final_wide;

    rbo_pair_stage u_pair (
        .x_code   (x_digit),
        .y_code   (y_digit),
        .pair_sum (pair_now),
        .neg_flag (neg_now)
    );

    // A start pair has no held neighbour above it: treat its pair sum as zero.
    always_comb psum_prev = in_start ? psum_t'(0) : psum_q;

    rbo_split_stage u_split (
        .pair_sum  (psum_prev),
        .lower_neg (neg_now),
        .carry_up  (carry_up),
        .interim   (interim_up)
    );

    // Final digit two positions above the current pair.
    always_comb final_wide = WIDE_W'(isum_q) + WIDE_W'(carry_up);

    // Advance the pipeline by one position on each accepted pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psum_q    <= '0;
            isum_q    <= '0;
            started_q <= 1'b0;
            out_valid <= 1'b0;
            out_digit <= '0;
        end else if (in_valid) begin
            psum_q    <= pair_now;
            isum_q    <= interim_up;
            started_q <= 1'b1;
            out_valid <= started_q & ~in_start;
            out_digit <= val_to_code(dig_t'(final_wide));
        end else begin
            out_valid <= 1'b0;
        end
    end

    // R1: the output never shows the unused code.
    a_r1_out_code: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_digit != 2'b10);

    // R1: held interim sum plus lower carry stays within one digit.
    a_r1_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && started_q && !in_start) |->
            (final_wide <= 3'sd1 && final_wide >= -3'sd1));

    // R3: the edge that accepts a start pair gives no output digit.
    a_r3_start_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_start) |=> !out_valid);

    // R5: an idle cycle gives no output digit and keeps the last digit.
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_digit)));

    // R7: the first edge after reset release still shows cleared outputs.
    a_r7_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && out_digit == 2'b00));
endmodule

// File: tb/tb_rbo_online_adder.sv
module tb_rbo_online_adder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_start = 1'b0;
    logic [1:0] x_digit = 2'b00;
    logic [1:0] y_digit = 2'b00;
    logic       out_valid;
    logic [1:0] out_digit;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    int xd [0:15];
    int yd [0:15];
    longint exp_sum [$];
    int     exp_len [$];
    longint acc = 0;
    int     got_n = 0;

    rbo_online_adder dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .x_digit(x_digit), .y_digit(y_digit),
        .out_valid(out_valid), .out_digit(out_digit)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] enc(input int v);
        return (v > 0) ? 2'b01 : (v < 0) ? 2'b11 : 2'b00;
    endfunction

    // Collector: reassemble the output digits MSD first and compare sums (R4).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            int dv;
            dv = (out_digit == 2'b01) ? 1 : (out_digit == 2'b11) ? -1 : 0;
            check(out_digit != 2'b10, "R1 output code", out_digit, 0);
            acc = acc * 2 + dv;
            got_n++;
            if (exp_len.size() == 0) begin
                check(1'b0, "R3 unexpected output digit", got_n, 0);
                got_n = 0; acc = 0;
            end else if (got_n == exp_len[0] + 1) begin
                check(acc == exp_sum[0], "R4 weighted sum", acc, exp_sum[0]);
                void'(exp_sum.pop_front());
                void'(exp_len.pop_front());
                acc = 0; got_n = 0;
            end
        end
    end

    // Send xd/yd[0..n-1] plus two flush pairs; gap inserts one idle cycle
    // after each pair; bad replaces some zero digits by the code 2'b10.
    task automatic run_stream(input int n, input bit gap, input bit bad);
        longint xs = 0;
        longint ys = 0;
        for (int k = 0; k < n; k++) begin
            xs = xs * 2 + xd[k];
            ys = ys * 2 + yd[k];
        end
        exp_sum.push_back(xs + ys);
        exp_len.push_back(n);
        for (int k = 0; k < n + 2; k++) begin
            int xv;
            int yv;
            xv = (k < n) ? xd[k] : 0;
            yv = (k < n) ? yd[k] : 0;
            @(negedge clk);
            if (k == 1)
                check(out_valid == 1'b0, "R3 silent after start pair", out_valid, 0);
            if (k == 2 && !gap)
                check(out_valid == 1'b1, "R3 valid after second pair", out_valid, 1);
            if (k > 0 && gap)
                check(out_valid == 1'b0, "R5 no output after idle cycle", out_valid, 0);
            in_valid = 1'b1;
            in_start = (k == 0);
            x_digit  = (bad && xv == 0 && ((k & 1) == 0)) ? 2'b10 : enc(xv);
            y_digit  = (bad && yv == 0 && ((k & 1) == 1)) ? 2'b10 : enc(yv);
            if (gap) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_start = 1'b0;
                x_digit  = 2'b01;
                y_digit  = 2'b11;
            end
        end
    endtask

    initial begin
        // R7: reset with activity on the inputs.
        in_valid = 1'b1; in_start = 1'b1; x_digit = 2'b01; y_digit = 2'b01;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R7 out_valid in reset", out_valid, 0);
        check(out_digit == 2'b00, "R7 out_digit in reset", out_digit, 0);
        in_valid = 1'b0; in_start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R7 out_valid after release", out_valid, 0);

        // R4, R2, R6: every pair of three-digit operands, back to back.
        for (int a = 0; a < 27; a++) begin
            for (int b = 0; b < 27; b++) begin
                int ta;
                int tb2;
                ta = a; tb2 = b;
                for (int k = 2; k >= 0; k--) begin
                    xd[k] = (ta % 3) - 1; ta = ta / 3;
                    yd[k] = (tb2 % 3) - 1; tb2 = tb2 / 3;
                end
                run_stream(3, 1'b0, 1'b0);
            end
        end

        // R4, R6: longer random streams back to back.
        for (int s = 0; s < 200; s++) begin
            for (int k = 0; k < 12; k++) begin
                xd[k] = $urandom_range(2) - 1;
                yd[k] = $urandom_range(2) - 1;
            end
            run_stream(12, 1'b0, 1'b0);
        end

        // R5: idle cycles between pairs leave the sum unchanged.
        for (int s = 0; s < 40; s++) begin
            for (int k = 0; k < 8; k++) begin
                xd[k] = $urandom_range(2) - 1;
                yd[k] = $urandom_range(2) - 1;
            end
            run_stream(8, 1'b1, 1'b0);
        end

        // R1: the unused input code acts as zero.
        for (int s = 0; s < 40; s++) begin
            for (int k = 0; k < 6; k++) begin
                xd[k] = $urandom_range(2) - 1;
                yd[k] = $urandom_range(2) - 1;
            end
            run_stream(6, 1'b0, 1'b1);
        end

        // Single-digit streams: the shortest case (R3 gives two outputs).
        for (int s = 0; s < 9; s++) begin
            xd[0] = (s % 3) - 1;
            yd[0] = (s / 3) - 1;
            run_stream(1, 1'b0, 1'b0);
        end

        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0;
        repeat (4) @(negedge clk);
        check(exp_len.size() == 0, "R3 all streams delivered", exp_len.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule